// File: doc/BRIEF.md
# Serial Port Register File and Flag Logic

This block is the software-visible face of a serial port controller on a 32-bit memory-mapped bus. It holds seven word registers: a status word, a data word, a baud-rate word, three control words and a guard-time/prescaler word. It also maintains the receive-full, transmit-empty and transmit-complete flags that drivers poll, and a single level interrupt for received data.

On the line side it does not serialize bits. Bytes written by software leave on a valid/ready byte stream. Bytes arriving from the line side enter on a second valid/ready stream. The receive stream only accepts a byte while no unread byte is held. Software drains the held byte by reading the data word, and reading that word lowers the interrupt.

Several bus accesses have side effects that drivers depend on. Reading status clears transmit-complete. A status write either loads the word or masks it, depending on the size of the value. Data writes at or above a threshold are dropped. Received bytes only raise flags when the port and its receiver are both enabled.

Top module: `usart_regif`

## Requirements
- R1: Word offsets decode as status 0x00, data 0x04, baud 0x08, control-1 0x0C, control-2 0x10, control-3 0x14 and guard/prescaler 0x18. Any other offset reads as zero, and a write to it changes no register.
- R2: After reset, status reads 0x00C00000 and every other register reads zero. `irq` and `tx_valid` are low and `rx_ready` is high.
- R3: `bus_rdata` takes the value addressed by a read strobe at the clock edge of that strobe. It holds that value until the next read strobe.
- R4: A status read returns the status word as it was before the strobe. Transmit-complete (status bit 6) is then cleared.
- R5: A data read returns the last received byte zero-extended in a 10-bit field. It also sets transmit-empty (status bit 7), clears receive-full (status bit 5) and lowers `irq`.
- R6: A status write with a value of at most 0x3FF replaces the status word. A larger value is ANDed into the word. In both cases `irq` is lowered if status bit 5 is clear afterwards; otherwise `irq` is left as it was.
- R7: A data write with a value below 0xF000, made while no byte is pending, puts bits 7:0 on `tx_data` with `tx_valid` high. It also sets status bit 6 and clears status bit 7. A data write of 0xF000 or more has no effect.
- R8: `tx_valid` and `tx_data` hold until a cycle with `tx_ready` high. A data write made while a byte is still pending has no effect on the stream or on the status word.
- R9: `rx_ready` is high exactly while status bit 5 is clear. Every accepted byte is stored as the data word, even when it raises no flag.
- R10: An accepted byte sets status bit 5 only when control-1 bit 13 (port enable) and bit 2 (receive enable) are both set. It then raises `irq` if control-1 bit 5 (receive interrupt enable) is set. Otherwise the byte changes no flag and no interrupt.
- R11: Writing control-1 with bit 5 set while status bit 5 is already set raises `irq` at that write.
- R12: Baud, control-1, control-2, control-3 and guard/prescaler store all 32 written bits and read them back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_addr | input | 6 | Word-aligned byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tx_data | output | 8 | Outgoing byte |
| tx_valid | output | 1 | Outgoing byte pending |
| tx_ready | input | 1 | Line side takes the outgoing byte |
| rx_data | input | 8 | Incoming byte |
| rx_valid | input | 1 | Incoming byte offered |
| rx_ready | output | 1 | Block can take an incoming byte |
| irq | output | 1 | Receive interrupt, level |

## Verification
Every result lands on the rising edge of the strobe or handshake that causes it. Read data, flag changes, the stream outputs and `irq` are all valid in the cycle after the stimulus. The only exception is `rx_ready`, which follows the status flag with no extra delay. The bench drives every input at a falling edge and lets one rising edge pass. It then compares all outputs against its behavioural model at the next falling edge, so every comparison falls exactly one edge after the stimulus. Targeted checks of fixed expected values are taken at that same falling edge, for example status words or the byte on the stream.

// File: rtl/usart_regif_pkg.sv
// Shared constants and types for the serial port register file.
// Assumes a 32-bit data bus and word-aligned byte offsets.
package usart_regif_pkg;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;
    localparam int BYTE_W = 8;
    localparam int DR_W   = 10;

    localparam logic [ADDR_W-1:0] OFF_STS = 6'h00;
    localparam logic [ADDR_W-1:0] OFF_DAT = 6'h04;
    localparam logic [ADDR_W-1:0] OFF_BRR = 6'h08;
    localparam logic [ADDR_W-1:0] OFF_C1  = 6'h0C;
    localparam logic [ADDR_W-1:0] OFF_C2  = 6'h10;
    localparam logic [ADDR_W-1:0] OFF_C3  = 6'h14;
    localparam logic [ADDR_W-1:0] OFF_GTP = 6'h18;

    // status bit positions
    localparam int SR_TXE  = 7;
    localparam int SR_TC   = 6;
    localparam int SR_RXNE = 5;
    // control-1 bit positions
    localparam int C1_EN   = 13;
    localparam int C1_RXIE = 5;
    localparam int C1_RXEN = 2;

    localparam logic [DATA_W-1:0] SR_RESET    = 32'h00C0_0000;
    localparam logic [DATA_W-1:0] SR_LOAD_MAX = 32'h0000_03FF;
    localparam logic [DATA_W-1:0] TX_LIMIT    = 32'h0000_F000;

    // stored-only configuration words, index order
    typedef enum logic [2:0] {
        CFG_BRR = 3'd0,
        CFG_C1  = 3'd1,
        CFG_C2  = 3'd2,
        CFG_C3  = 3'd3,
        CFG_GTP = 3'd4
    } cfg_idx_e;
    localparam int N_CFG = 5;

    typedef struct packed {
        logic             sts;
        logic             dat;
        logic [N_CFG-1:0] cfg;
    } regsel_t;

endpackage

// File: rtl/usart_regif_dec.sv
// Offset decoder: turns a word-aligned byte offset into one-hot register selects.
// Assumes offsets outside the map select nothing.
module usart_regif_dec
    import usart_regif_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] addr,
    output regsel_t       sel
);

    // map the offset onto at most one register select
    always_comb begin
        sel = '0;
        case (addr)
            AW'(OFF_STS): sel.sts = 1'b1;
            AW'(OFF_DAT): sel.dat = 1'b1;
            AW'(OFF_BRR): sel.cfg[CFG_BRR] = 1'b1;
            AW'(OFF_C1):  sel.cfg[CFG_C1]  = 1'b1;
            AW'(OFF_C2):  sel.cfg[CFG_C2]  = 1'b1;
            AW'(OFF_C3):  sel.cfg[CFG_C3]  = 1'b1;
            AW'(OFF_GTP): sel.cfg[CFG_GTP] = 1'b1;
            default:      sel = '0;
        endcase
    end

endmodule

// File: rtl/usart_regif_cfg.sv
// Bank of plain read/write configuration words.
// Assumes at most one select bit is high; a write loads the whole word.
module usart_regif_cfg #(
    parameter int DW = 32,
    parameter int N  = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [N-1:0]         wr_sel,
    input  logic [DW-1:0]        wdata,
    output logic [N-1:0][DW-1:0] word
);

    for (genvar g = 0; g < N; g++) begin : g_word
        logic [DW-1:0] q;

        // load this word on a selected write, clear on reset
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en && wr_sel[g]) begin
                q <= wdata;
            end
        end

        assign word[g] = q;
    end

endmodule

// File: rtl/usart_regif_tx.sv
// Transmit holding stage: presents one byte on a valid/ready stream.
// Assumes load is only raised while no byte is pending.
module usart_regif_tx #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [BW-1:0] byte_in,
    input  logic          ready,
    output logic          valid,
    output logic [BW-1:0] data
);

    // capture a byte on load, release it on the consumer's handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            data  <= '0;
        end else if (load) begin
            valid <= 1'b1;
            data  <= byte_in;
        end else if (valid && ready) begin
            valid <= 1'b0;
        end
    end

endmodule

// File: rtl/usart_regif_flags.sv
// Status word, received-data word and receive interrupt.
// Assumes at most one bus strobe per cycle. The bus event is applied first and the
// receive event after it, so a byte arriving in the same cycle wins.
module usart_regif_flags
    import usart_regif_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int BW = BYTE_W,
    parameter int RW = DR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_sts,
    input  logic          rd_dat,
    input  logic          wr_sts,
    input  logic          wr_c1,
    input  logic [DW-1:0] wdata,
    input  logic          tx_load,
    input  logic          rx_fire,
    input  logic [BW-1:0] rx_byte,
    input  logic          rx_en,
    input  logic          ie_cur,
    output logic [DW-1:0] sr_q,
    output logic [RW-1:0] dr_q,
    output logic          irq_q
);

    logic [DW-1:0] sr_n;
    logic [RW-1:0] dr_n;
    logic          irq_n;
    logic          ie_new;

    assign ie_new = wdata[C1_RXIE];

    // next-state of flags, data word and interrupt from this cycle's events
    always_comb begin
        sr_n  = sr_q;
        dr_n  = dr_q;
        irq_n = irq_q;
        if (rd_sts) begin
            sr_n[SR_TC] = 1'b0;
        end
        if (rd_dat) begin
            sr_n[SR_TXE]  = 1'b1;
            sr_n[SR_RXNE] = 1'b0;
            irq_n         = 1'b0;
        end
        if (wr_sts) begin
            if (wdata <= DW'(SR_LOAD_MAX)) begin
                sr_n = wdata;
            end else begin
                sr_n = sr_n & wdata;
            end
            if (!sr_n[SR_RXNE]) begin
                irq_n = 1'b0;
            end
        end
        if (tx_load) begin
            sr_n[SR_TC]  = 1'b1;
            sr_n[SR_TXE] = 1'b0;
        end
        if (wr_c1 && ie_new && sr_n[SR_RXNE]) begin
            irq_n = 1'b1;
        end
        if (rx_fire) begin
            dr_n = RW'(rx_byte);
            if (rx_en) begin
                sr_n[SR_RXNE] = 1'b1;
                if (ie_cur) begin
                    irq_n = 1'b1;
                end
            end
        end
    end

    // register the flag state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q  <= DW'(SR_RESET);
            dr_q  <= '0;
            irq_q <= 1'b0;
        end else begin
            sr_q  <= sr_n;
            dr_q  <= dr_n;
            irq_q <= irq_n;
        end
    end

endmodule

// File: rtl/usart_regif.sv
// Serial port register file: bus decode, flags, config words and byte streams.
// Assumes single-cycle strobes, never a read and a write in the same cycle,
// and registered read data one cycle after the strobe.
module usart_regif
    import usart_regif_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int BW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic [BW-1:0] tx_data,
    output logic          tx_valid,
    input  logic          tx_ready,
    input  logic [BW-1:0] rx_data,
    input  logic          rx_valid,
    output logic          rx_ready,
    output logic          irq
);

    localparam int RW = DR_W;

    regsel_t                     sel;
    logic [N_CFG-1:0][DW-1:0]    cfg_word;
    logic [DW-1:0]               ctrl1;
    logic [DW-1:0]               sr_q;
    logic [RW-1:0]               dr_q;
    logic                        tx_load;
    logic                        rx_fire;
    logic [DW-1:0]               rd_val;

    usart_regif_dec #(.AW(AW)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    usart_regif_cfg #(.DW(DW), .N(N_CFG)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_wr),
        .wr_sel (sel.cfg),
        .wdata  (bus_wdata),
        .word   (cfg_word)
    );

    assign ctrl1    = cfg_word[CFG_C1];
    assign tx_load  = bus_wr && sel.dat && (bus_wdata < DW'(TX_LIMIT)) && !tx_valid;
    assign rx_ready = !sr_q[SR_RXNE];
    assign rx_fire  = rx_valid && rx_ready;

    usart_regif_tx #(.BW(BW)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tx_load),
        .byte_in (bus_wdata[BW-1:0]),
        .ready   (tx_ready),
        .valid   (tx_valid),
        .data    (tx_data)
    );

    usart_regif_flags #(.DW(DW), .BW(BW), .RW(RW)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_sts  (bus_rd && sel.sts),
        .rd_dat  (bus_rd && sel.dat),
        .wr_sts  (bus_wr && sel.sts),
        .wr_c1   (bus_wr && sel.cfg[CFG_C1]),
        .wdata   (bus_wdata),
        .tx_load (tx_load),
        .rx_fire (rx_fire),
        .rx_byte (rx_data),
        .rx_en   (ctrl1[C1_EN] && ctrl1[C1_RXEN]),
        .ie_cur  (ctrl1[C1_RXIE]),
        .sr_q    (sr_q),
        .dr_q    (dr_q),
        .irq_q   (irq)
    );

    // select the addressed word; unmapped offsets give zero
    always_comb begin
        rd_val = '0;
        if (sel.sts) rd_val = sr_q;
        if (sel.dat) rd_val = DW'(dr_q);
        for (int i = 0; i < N_CFG; i++) begin
            if (sel.cfg[i]) rd_val = cfg_word[i];
        end
    end

    // register read data on each read strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_val;
        end
    end

endmodule

// File: rtl/usart_regif_chk.sv
// Property checker for the serial port register file, bound to the top module.
// Assumes exclusive read and write strobes, as the top module does.
module usart_regif_chk
    import usart_regif_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [BYTE_W-1:0] tx_data,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              irq,
    input logic [DATA_W-1:0] sr_q
);

    a_r2_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!irq && !tx_valid && rx_ready));

    a_r4_tc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == OFF_STS) |=> !sr_q[SR_TC]);

    a_r5_data_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == OFF_DAT && !(rx_valid && rx_ready))
        |=> (!irq && sr_q[SR_TXE] && !sr_q[SR_RXNE]));

    a_r7_tx_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_rd && bus_addr == OFF_DAT && bus_wdata < TX_LIMIT && !tx_valid)
        |=> (tx_valid && tx_data == $past(bus_wdata[BYTE_W-1:0])
             && sr_q[SR_TC] && !sr_q[SR_TXE]));

    a_r8_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    a_r10_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> sr_q[SR_RXNE]);

endmodule

bind usart_regif usart_regif_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .irq       (irq),
    .sr_q      (sr_q)
);

// File: tb/test_usart_regif.sv
// Bench for usart_regif. A behavioural model is advanced on every rising edge and
// compared with the outputs on every falling edge. Targeted checks use fixed values.
module test_usart_regif;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic        irq;

    int    total = 0;
    int    bad = 0;
    int    cycles = 0;
    bit    done = 1'b0;
    string tag = "R2";

    usart_regif i_usart_regif (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural model ----------------
    logic [31:0] m_sr = 32'h00C0_0000;
    logic [9:0]  m_dr = '0;
    logic [31:0] m_cfg [5];
    logic        m_irq = 1'b0;
    logic        m_txv = 1'b0;
    logic [7:0]  m_txd = '0;
    logic [31:0] m_rd = '0;
    bit          m_live = 1'b0;

    function automatic logic [31:0] m_read(input logic [5:0] a);
        if (a == 6'h00) return m_sr;
        if (a == 6'h04) return {22'b0, m_dr};
        if (a >= 6'h08 && a <= 6'h18 && a[1:0] == 2'b00) return m_cfg[(a - 6'h08) >> 2];
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sr = 32'h00C0_0000; m_dr = '0; m_irq = 0; m_txv = 0; m_txd = '0; m_rd = '0;
            for (int i = 0; i < 5; i++) m_cfg[i] = '0;
            m_live = 1'b1;
        end else begin
            logic        old_txv, old_full;
            logic [31:0] old_c1;
            old_txv  = m_txv;
            old_full = m_sr[5];
            old_c1   = m_cfg[1];
            if (bus_rd) begin
                m_rd = m_read(bus_addr);
                if (bus_addr == 6'h00) m_sr[6] = 0;
                if (bus_addr == 6'h04) begin m_sr[7] = 1; m_sr[5] = 0; m_irq = 0; end
            end
            if (m_txv && tx_ready) m_txv = 0;
            if (bus_wr) begin
                if (bus_addr == 6'h00) begin
                    m_sr = (bus_wdata <= 32'h3FF) ? bus_wdata : (m_sr & bus_wdata);
                    if (!m_sr[5]) m_irq = 0;
                end else if (bus_addr == 6'h04) begin
                    if (bus_wdata < 32'hF000 && !old_txv) begin
                        m_txv = 1; m_txd = bus_wdata[7:0]; m_sr[6] = 1; m_sr[7] = 0;
                    end
                end else if (bus_addr >= 6'h08 && bus_addr <= 6'h18 && bus_addr[1:0] == 2'b00) begin
                    m_cfg[(bus_addr - 6'h08) >> 2] = bus_wdata;
                    if (bus_addr == 6'h0C && bus_wdata[5] && m_sr[5]) m_irq = 1;
                end
            end
            if (rx_valid && !old_full) begin
                m_dr = {2'b00, rx_data};
                if (old_c1[13] && old_c1[2]) begin
                    m_sr[5] = 1;
                    if (old_c1[5]) m_irq = 1;
                end
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // compare every output against the model one edge after each stimulus
    always @(negedge clk) begin
        if (rst_n && m_live && !done) begin
            chk(tag, "model irq", {31'b0, irq}, {31'b0, m_irq});
            chk(tag, "model tx_valid", {31'b0, tx_valid}, {31'b0, m_txv});
            if (m_txv) chk(tag, "model tx_data", {24'b0, tx_data}, {24'b0, m_txd});
            chk(tag, "model rx_ready", {31'b0, rx_ready}, {31'b0, !m_sr[5]});
            chk(tag, "model rdata", bus_rdata, m_rd);
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string req);
        @(negedge clk); bus_rd = 1; bus_addr = a;
        @(negedge clk); bus_rd = 0;
        chk(req, "read", bus_rdata, exp);
    endtask

    task automatic rx(input logic [7:0] b);
        @(negedge clk); rx_valid = 1; rx_data = b;
        @(negedge clk); rx_valid = 0;
    endtask

    // watchdog
    initial begin
        while (!done && cycles < 20000) begin @(posedge clk); cycles++; end
        if (!done) begin
            done = 1'b1; total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=<20000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R2 reset state
        tag = "R2";
        chk("R2", "irq", {31'b0, irq}, 0);
        chk("R2", "tx_valid", {31'b0, tx_valid}, 0);
        chk("R2", "rx_ready", {31'b0, rx_ready}, 1);
        rd(6'h00, 32'h00C0_0000, "R2");
        rd(6'h08, 0, "R2"); rd(6'h0C, 0, "R2"); rd(6'h10, 0, "R2");
        rd(6'h14, 0, "R2"); rd(6'h18, 0, "R2");

        // R12 config store and readback
        tag = "R12";
        wr(6'h08, 32'h1234_5678); wr(6'h10, 32'hDEAD_BEEF);
        wr(6'h14, 32'h0000_0A5A); wr(6'h18, 32'hFFFF_0001);
        rd(6'h08, 32'h1234_5678, "R12"); rd(6'h10, 32'hDEAD_BEEF, "R12");
        rd(6'h14, 32'h0000_0A5A, "R12"); rd(6'h18, 32'hFFFF_0001, "R12");

        // R1 unmapped offsets
        tag = "R1";
        wr(6'h1C, 32'hCAFE_F00D); wr(6'h3C, 32'h0BAD_0BAD);
        rd(6'h1C, 0, "R1"); rd(6'h3C, 0, "R1"); rd(6'h20, 0, "R1");
        rd(6'h08, 32'h1234_5678, "R1"); rd(6'h18, 32'hFFFF_0001, "R1");

        // R3 read data held between strobes
        tag = "R3";
        repeat (3) @(negedge clk);
        chk("R3", "rdata held", bus_rdata, 32'hFFFF_0001);

        // R7 transmit launch, R4 status read clears complete flag
        tag = "R7";
        wr(6'h04, 32'h0000_01A5);
        chk("R7", "tx_valid", {31'b0, tx_valid}, 1);
        chk("R7", "tx_data", {24'b0, tx_data}, 32'hA5);
        tag = "R4";
        rd(6'h00, 32'h00C0_0040, "R4");
        rd(6'h00, 32'h00C0_0000, "R4");

        // R8 pending byte held, second write ignored
        tag = "R8";
        wr(6'h04, 32'h0000_0077);
        repeat (2) @(negedge clk);
        chk("R8", "tx_data held", {24'b0, tx_data}, 32'hA5);
        rd(6'h00, 32'h00C0_0000, "R8");
        tx_ready = 1;
        @(negedge clk);
        chk("R8", "tx_valid after handshake", {31'b0, tx_valid}, 0);

        // R7 threshold
        tag = "R7";
        wr(6'h04, 32'h0000_F000);
        chk("R7", "tx_valid on 0xF000", {31'b0, tx_valid}, 0);
        wr(6'h04, 32'h0000_EFFF);
        chk("R7", "tx_data on 0xEFFF", {24'b0, tx_data}, 32'hFF);
        @(negedge clk);

        // R9/R10 disabled receive still stores the byte
        tag = "R10";
        rx(8'h3C);
        chk("R10", "irq disabled", {31'b0, irq}, 0);
        chk("R10", "rx_ready disabled", {31'b0, rx_ready}, 1);
        tag = "R9";
        rd(6'h04, 32'h0000_003C, "R9");
        tag = "R5";
        rd(6'h00, 32'h00C0_00C0, "R5");

        // R10 enabled, no interrupt
        tag = "R10";
        wr(6'h0C, 32'h0000_2004);
        rx(8'h81);
        chk("R9", "rx_ready full", {31'b0, rx_ready}, 0);
        chk("R10", "irq no ie", {31'b0, irq}, 0);
        rx(8'h22);
        tag = "R9";
        rd(6'h04, 32'h0000_0081, "R9");
        chk("R9", "rx_ready drained", {31'b0, rx_ready}, 1);

        // R10 with interrupt enable, R5 read lowers irq
        tag = "R10";
        wr(6'h0C, 32'h0000_2024);
        rd(6'h0C, 32'h0000_2024, "R12");
        rx(8'h5E);
        chk("R10", "irq raised", {31'b0, irq}, 1);
        tag = "R5";
        rd(6'h04, 32'h0000_005E, "R5");
        chk("R5", "irq lowered", {31'b0, irq}, 0);

        // R11 late interrupt enable
        tag = "R11";
        wr(6'h0C, 32'h0000_2004);
        rx(8'h11);
        chk("R11", "irq before enable", {31'b0, irq}, 0);
        wr(6'h0C, 32'h0000_2024);
        chk("R11", "irq after enable", {31'b0, irq}, 1);

        // R6 status write replace and mask
        tag = "R6";
        wr(6'h00, 32'h0000_03FF);
        chk("R6", "irq kept", {31'b0, irq}, 1);
        wr(6'h00, 32'h0000_01DF);
        chk("R6", "irq dropped", {31'b0, irq}, 0);
        rd(6'h00, 32'h0000_01DF, "R6");
        rd(6'h00, 32'h0000_019F, "R4");
        wr(6'h00, 32'hFFFF_FF7F);
        rd(6'h00, 32'h0000_011F, "R6");
        rx(8'h99);
        chk("R6", "irq set again", {31'b0, irq}, 1);
        wr(6'h00, 32'hFFFF_FFFF);
        chk("R6", "irq kept by mask", {31'b0, irq}, 1);
        wr(6'h00, 32'hFFFF_FFDF);
        chk("R6", "irq dropped by mask", {31'b0, irq}, 0);
        chk("R6", "rx_ready after mask", {31'b0, rx_ready}, 1);
        rd(6'h00, 32'h0000_011F, "R6");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule